// File: doc/BRIEF.md
# Receive Packet Address Filter

This block sits at the front of a packet receiver and decides whether an incoming packet is kept. It makes that decision from the first word the receiver delivers, before any payload is written to memory. The high byte of that word is the destination station. The low byte carries the sender's station and plays no part in the decision. The filter accepts a packet in four cases:
- the local station register holds zero (promiscuous mode);
- the destination is zero (broadcast);
- the destination equals the local station;
- the destination equals a fixed monitoring-report address (0xFE by default).

Every other packet is rejected. The reject pulse re-arms the receiver, which then skips the rest of the packet and waits for the first word of the next one.

The filter only looks at the first word. It never advances the receiver's read position, so an accepted packet still starts at that word. The decision is held off while the enable input is low. A counter of word-time ticks limits how long the held decision may wait. After the configured number of ticks (14 by default), the pending packet is dropped with a reject pulse and a sticky late-decision flag is raised before the receive buffer can overflow.

Top module: `rx_addr_filter`

## Requirements
- R1: A packet whose destination byte (first word bits [15:8]) equals a non-zero local station value produces an accept pulse.
- R2: A destination byte of 0x00 produces an accept pulse for any local station value.
- R3: A destination byte equal to the monitoring address (parameter, default 0xFE) produces an accept pulse.
- R4: When the local station value is 0x00, every captured first word produces an accept pulse.
- R5: Bits [7:0] of the first word have no effect on the decision, even when they equal the local station value.
- R6: Any destination not covered by R1 to R4 produces a reject pulse, which re-arms the receiver.
- R7: Each captured first word yields exactly one one-cycle pulse, on either accept or reject and never both. With enable high, the pulse is high in the cycle after the clock edge that follows the capturing edge.
- R8: While enable is low, a captured word is held and no pulse is issued. The decision is made at the first edge where enable is high, against the held word.
- R9: A first-word strobe that arrives while a decision is pending is dropped, and the pending decision uses the earlier word.
- R10: If 14 word-time ticks (parameter) are counted while a decision is pending and enable stays low, a reject pulse is issued on the 14th tick and the late-decision flag goes high. The flag stays high until the next first word is captured.
- R11: After reset, accept, reject and the late-decision flag are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Permits the pending decision to be issued |
| station | input | 8 | Local station value; zero selects promiscuous mode |
| first_valid | input | 1 | One-cycle strobe marking the first word of a packet |
| first_word | input | 16 | First received word: destination in [15:8], source in [7:0] |
| word_tick | input | 1 | One-cycle pulse per received word time |
| accept_o | output | 1 | One-cycle pulse: keep the packet |
| reject_o | output | 1 | One-cycle pulse: drop the packet and re-arm the receiver |
| late_o | output | 1 | Sticky flag: the decision deadline was missed |

## Verification
The bench places the local station value in the low byte of the first word. A filter that compares the wrong byte would accept that packet instead of rejecting it. Station zero is paired with arbitrary destinations, which catches a design that treats zero only as broadcast and never as promiscuous. The deadline is tested one tick short of the limit and then exactly at it, which exposes a counter that is off by one or drops the packet silently. A second strobe is sent while a decision is held, so a design that overwrote the held word would decide on the wrong packet.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Which acceptance rule fired for the held first word.
  typedef struct packed {
    logic promisc;
    logic bcast;
    logic own;
    logic monitor;
  } rxf_hits_t;
endpackage

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter logic [ADDR_W-1:0] MON_ADDR = 8'hFE
) (
  input  logic [ADDR_W-1:0] station,
  input  logic [WORD_W-1:0] word,
  output rxf_hits_t         hits,
  output logic              hit
);
  localparam int DEST_LO = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] dest;

  generate
    if (WORD_W < 2 * ADDR_W) begin : g_bad_width
      initial $error("rxf_match: word too narrow for destination and source");
    end
  endgenerate

  // Destination is the top byte; the source byte below is masked off.
  assign dest = word[WORD_W-1:DEST_LO];

  always_comb begin
    hits.promisc = (station == '0);
    hits.bcast   = (dest == '0);
    hits.own     = (dest == station);
    hits.monitor = (dest == MON_ADDR);
    hit          = |hits;
  end
endmodule

// File: rtl/rxf_deadline.sv
module rxf_deadline #(
  parameter int TICKS = 14,
  localparam int CNT_W = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = count_en && (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (count_en && (cnt_q != LAST)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R10: tick count never exceeds the deadline window
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rxf_seq.sv
module rxf_seq #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              first_valid,
  input  logic [WORD_W-1:0] first_word,
  input  logic              hit,
  input  logic              expire,
  output logic [WORD_W-1:0] word_q,
  output logic              pending_q,
  output logic              capture,
  output logic              accept_q,
  output logic              reject_q,
  output logic              late_q
);
  logic              decide, drop;
  logic              pending_d, accept_d, reject_d, late_d;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    capture   = first_valid && !pending_q;
    decide    = pending_q && enable;
    drop      = pending_q && !enable && expire;
    pending_d = pending_q;
    if (capture) begin
      pending_d = 1'b1;
    end else if (decide || drop) begin
      pending_d = 1'b0;
    end
    word_d   = capture ? first_word : word_q;
    accept_d = decide && hit;
    reject_d = (decide && !hit) || drop;
    late_d   = late_q;
    if (drop) begin
      late_d = 1'b1;
    end else if (capture) begin
      late_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      accept_q  <= 1'b0;
      reject_q  <= 1'b0;
      late_q    <= 1'b0;
      word_q    <= '0;
    end else begin
      pending_q <= pending_d;
      accept_q  <= accept_d;
      reject_q  <= reject_d;
      late_q    <= late_d;
      if (capture) begin
        word_q <= word_d;
      end
    end
  end

  assert_one_of_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_q && reject_q));
  assert_accept_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_q |=> !accept_q);
  assert_reject_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject_q |=> !reject_q);
  assert_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept_q) || $rose(reject_q) |-> $past(pending_q));
  assert_hold_while_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && !enable && !expire |=> pending_q && !accept_q);
  assert_drop_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |=> $stable(word_q));
  assert_late_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> reject_q);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter logic [ADDR_W-1:0] MON_ADDR = 8'hFE,
  parameter int DEADLINE_TICKS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] station,
  input  logic              first_valid,
  input  logic [WORD_W-1:0] first_word,
  input  logic              word_tick,
  output logic              accept_o,
  output logic              reject_o,
  output logic              late_o
);
  logic [WORD_W-1:0] word_q;
  logic              pending, capture, hit, expire;
  rxf_hits_t         hits;

  rxf_match #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .MON_ADDR(MON_ADDR)) u_match (
    .station (station),
    .word    (word_q),
    .hits    (hits),
    .hit     (hit)
  );

  rxf_deadline #(.TICKS(DEADLINE_TICKS)) u_deadline (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (capture),
    .count_en (pending && word_tick),
    .expire   (expire)
  );

  rxf_seq #(.WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .first_valid (first_valid),
    .first_word  (first_word),
    .hit         (hit),
    .expire      (expire),
    .word_q      (word_q),
    .pending_q   (pending),
    .capture     (capture),
    .accept_q    (accept_o),
    .reject_q    (reject_o),
    .late_q      (late_o)
  );

  // R4: zero station accepts whatever is pending
  assert_promisc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pending && enable && (station == '0) |=> accept_o);
  // R2: zero destination accepted
  assert_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pending && enable && (word_q[WORD_W-1 -: ADDR_W] == '0) |=> accept_o);
  // R3: monitoring address accepted
  assert_monitor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pending && enable && (word_q[WORD_W-1 -: ADDR_W] == MON_ADDR) |=> accept_o);
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [7:0]  station;
  logic        first_valid;
  logic [15:0] first_word;
  logic        word_tick;
  logic        accept_o, reject_o, late_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .station(station),
    .first_valid(first_valid), .first_word(first_word), .word_tick(word_tick),
    .accept_o(accept_o), .reject_o(reject_o), .late_o(late_o)
  );

  // {station[7:0], word[15:0], expect_accept}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {8'h21, 16'h2105, 1'b1},  // R1 own
    {8'h21, 16'h0033, 1'b1},  // R2 broadcast
    {8'h21, 16'hFE44, 1'b1},  // R3 monitor
    {8'h21, 16'h2200, 1'b0},  // R6 other
    {8'h00, 16'h7712, 1'b1},  // R4 promiscuous
    {8'h21, 16'h1021, 1'b0},  // R5 source byte equals station
    {8'hFE, 16'hFE00, 1'b1},  // R1/R3 overlap
    {8'h21, 16'hFF21, 1'b0},  // R5 / R6
    {8'h80, 16'h80FF, 1'b1},  // R1 own, high bit
    {8'h21, 16'hFD00, 1'b0}   // R6 near monitor
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] st, input logic [15:0] w);
    @(negedge clk);
    station     = st;
    first_word  = w;
    first_valid = 1'b1;
    @(negedge clk);
    first_valid = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      word_tick = 1'b1;
      @(negedge clk);
      word_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; station = 8'h21;
    first_valid = 1'b0; first_word = '0; word_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 accept reset", accept_o, 0);
    chk("R11 reject reset", reject_o, 0);
    chk("R11 late reset", late_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][24:17], VEC[i][16:1]);
      chk($sformatf("R7 no early pulse v%0d", i), {accept_o, reject_o}, 0);
      @(negedge clk);
      chk($sformatf("R1-R6 v%0d accept", i), accept_o, VEC[i][0]);
      chk($sformatf("R6 v%0d reject", i), reject_o, !VEC[i][0]);
      @(negedge clk);
      chk($sformatf("R7 single pulse v%0d", i), {accept_o, reject_o}, 0);
    end

    // R8: decision deferred while disabled
    enable = 1'b0;
    strobe(8'h21, 16'h2100);
    tick_n(3);
    chk("R8 held no pulse", {accept_o, reject_o}, 0);
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    chk("R8 accept after enable", accept_o, 1);
    @(negedge clk);

    // R9: second strobe while pending dropped
    enable = 1'b0;
    strobe(8'h21, 16'h2111);
    strobe(8'h21, 16'h5511);
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    chk("R9 first word decides", accept_o, 1);
    chk("R9 no reject", reject_o, 0);
    @(negedge clk);
    chk("R9 only one pulse", {accept_o, reject_o}, 0);

    // R10: deadline
    enable = 1'b0;
    strobe(8'h21, 16'h2100);
    tick_n(13);
    chk("R10 13 ticks no pulse", {accept_o, reject_o}, 0);
    chk("R10 13 ticks no late", late_o, 0);
    @(negedge clk); word_tick = 1'b1;
    @(negedge clk); word_tick = 1'b0;
    chk("R10 reject at 14th tick", reject_o, 1);
    chk("R10 late raised", late_o, 1);
    @(negedge clk);
    chk("R10 reject single", reject_o, 0);
    chk("R10 late sticky", late_o, 1);
    enable = 1'b1;
    @(negedge clk);
    chk("R10 no decision after drop", {accept_o, reject_o}, 0);
    strobe(8'h21, 16'h0000);
    chk("R10 late cleared by capture", late_o, 0);
    @(negedge clk);
    chk("R2 broadcast after drop", accept_o, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule